// File: doc/BRIEF.md
# Posted-Write Dual-Domain Timer

This block is a 32-bit up-counting timer. Its counter, prescaler, compare logic and PWM output run on their own functional clock. Its register file sits on the bus clock. Every register that the counting logic uses is kept on the bus side and copied into the functional domain by its own toggle handshake channel. A bitmap shows which of these copies are still travelling.

In posted mode a write to one of these registers finishes on the bus in the same cycle. Software can then poll the pending bitmap. A write to a register whose transfer has not finished is discarded. In non-posted mode the bus is held until the register's transfer completes. The counter can be preset directly or reloaded from the load register through the trigger register. It can divide its clock, reload itself on overflow or halt there, and raise a compare event. Overflow and match events come back to the bus domain as sticky status bits. The interrupt line is those status bits masked by an enable register. The PWM pin can toggle or pulse on a selectable set of events around a programmable idle level.

Register word addresses: 0 control, 1 counter, 2 load, 3 trigger, 4 compare value, 5 pending bitmap (read only), 6 status, 7 interrupt enable, 8 interface control (bit 0 = posted mode). Control bits: 0 run, 1 auto-reload, [4:2] prescale ratio, 5 prescale enable, 6 compare enable, 7 PWM idle level, [11:10] PWM event select, 12 PWM toggle mode.

Top module: `posted_timer`

## Requirements
- R1: After reset every register reads 0, including the interface control register, so the block starts in non-posted mode. irq and pwm_out are 0.
- R2: In posted mode a write to address 0..4 completes with bus_ready high in the same cycle. From the next cycle the matching bit of the pending bitmap is 1 (bit 0 control, 1 counter, 2 load, 3 trigger, 4 compare). The bit returns to 0 once the value has reached the functional domain.
- R3: In non-posted mode a write to address 0..4 holds bus_ready low for at least one cycle. When the write completes, its pending bit is already 0, and the written value is in effect.
- R4: In posted mode a write to a register whose pending bit is 1 is discarded: the register keeps its earlier value.
- R5: A write to the counter register presets the count. Reading address 1 returns the count after one handshake round trip.
- R6: Any write to the trigger register copies the load register into the counter.
- R7: With prescale enable (bit 5) set, the counter advances once every 2^(ratio+1) functional clocks. With bit 5 clear, it advances on every functional clock.
- R8: With auto-reload (bit 1) set, the counter reloads from the load register when it passes all-ones, so overflows come every (2^32 - load) counter steps.
- R9: With auto-reload clear, the counter wraps to 0 on overflow and stays there.
- R10: Clearing the run bit freezes the counter once the control write has landed.
- R11: With compare enable (bit 6) set, a match event occurs when the counter steps onto the compare value. It sets status bit 1.
- R12: PWM event select: 00 = none, 01 = overflow, 10 = overflow or match. In toggle mode (bit 12 = 1) each event inverts pwm_out. In pulse mode pwm_out rests at the idle level (bit 7) and inverts for one functional clock per event. A control write that lands sets pwm_out to the idle level.
- R13: Status bit 0 records overflow and bit 1 records match. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle takes priority over the clear. irq is high when any status bit is 1 and its enable bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| fclk | input | 1 | Functional (counting) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_we | input | 1 | Write request, held until bus_ready |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| bus_ready | output | 1 | Write completes in a cycle where bus_we and bus_ready are both high |
| irq | output | 1 | Masked interrupt request |
| pwm_out | output | 1 | PWM / event output, functional clock domain |

## Verification
If a handshake channel is stuck or misordered, a pending bit stays at 1 or never rises. This shows on the bitmap within a few bus cycles, and in non-posted mode it shows as bus_ready staying low. A wrong prescaler or reload state shows as a wrong spacing of edges on pwm_out, measured exactly in functional clocks, within the first two event periods. A lost or duplicated event shows as a status or irq value that disagrees with the control settings as soon as the timer has been stopped and its events have drained.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned NCH    = 5;   // posted registers, one channel each

    // channel index equals the word address of the posted register
    localparam int unsigned CH_CTRL  = 0;
    localparam int unsigned CH_COUNT = 1;
    localparam int unsigned CH_LOAD  = 2;
    localparam int unsigned CH_TRIG  = 3;
    localparam int unsigned CH_MATCH = 4;

    localparam logic [ADDR_W-1:0] AD_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] AD_COUNT = 4'd1;
    localparam logic [ADDR_W-1:0] AD_LOAD  = 4'd2;
    localparam logic [ADDR_W-1:0] AD_TRIG  = 4'd3;
    localparam logic [ADDR_W-1:0] AD_MATCH = 4'd4;
    localparam logic [ADDR_W-1:0] AD_PEND  = 4'd5;
    localparam logic [ADDR_W-1:0] AD_STAT  = 4'd6;
    localparam logic [ADDR_W-1:0] AD_IEN   = 4'd7;
    localparam logic [ADDR_W-1:0] AD_IFC   = 4'd8;

    typedef struct packed {
        logic       tgl;     // bit 12
        logic [1:0] evsel;   // bits 11:10
        logic       idle;    // bit 7
        logic       cmp_en;  // bit 6
        logic       pre_en;  // bit 5
        logic [2:0] ratio;   // bits 4:2
        logic       arl;     // bit 1
        logic       run;     // bit 0
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.tgl    = w[12];
        c.evsel  = w[11:10];
        c.idle   = w[7];
        c.cmp_en = w[6];
        c.pre_en = w[5];
        c.ratio  = w[4:2];
        c.arl    = w[1];
        c.run    = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w       = '0;
        w[12]   = c.tgl;
        w[11:10]= c.evsel;
        w[7]    = c.idle;
        w[6]    = c.cmp_en;
        w[5]    = c.pre_en;
        w[4:2]  = c.ratio;
        w[1]    = c.arl;
        w[0]    = c.run;
        return w;
    endfunction
endpackage

// File: rtl/ptmr_sync.sv
module ptmr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ptmr_xfer.sv
// Toggle handshake: one transfer in flight at a time; data is held
// stable by the source while busy is high.
module ptmr_xfer #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic land
);
    logic req_q, req_s, seen_q, ack_s;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n)                 req_q <= 1'b0;
        else if (start && !busy)    req_q <= ~req_q;
    end

    ptmr_sync #(.STAGES(STAGES)) u_req (.clk(dst_clk), .rst_n(rst_n), .d(req_q), .q(req_s));

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_s;
    end

    assign land = req_s ^ seen_q;

    ptmr_sync #(.STAGES(STAGES)) u_ack (.clk(src_clk), .rst_n(rst_n), .d(seen_q), .q(ack_s));

    assign busy = req_q ^ ack_s;
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PRE_W = 3
) (
    input  logic             fclk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   land_i,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             snap_busy_i,
    input  logic [1:0]       ev_busy_i,
    output logic             snap_start_o,
    output logic [CNT_W-1:0] snap_o,
    output logic [1:0]       ev_start_o,
    output logic             pwm_o
);
    localparam int unsigned DIV_W = 1 << PRE_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
        logic [CNT_W-1:0] snap;
        logic [DIV_W-1:0] pre;
        logic [1:0]       evp;
        logic             pwm;
    } core_t;

    core_t q, d;
    logic  tick, ovf, mat, evt;
    logic [DIV_W:0] lim;
    logic [1:0] ev_go;

    always_comb begin
        d    = q;
        ovf  = 1'b0;
        mat  = 1'b0;
        lim  = ((DIV_W+1)'(1) << ({1'b0, q.ctrl.ratio} + 4'd1)) - 1'b1;
        tick = !q.ctrl.pre_en || (q.pre == lim[DIV_W-1:0]);

        if (q.ctrl.run) begin
            d.pre = tick ? '0 : q.pre + 1'b1;
            if (tick) begin
                if (&q.cnt) begin
                    ovf   = 1'b1;
                    d.cnt = q.ctrl.arl ? q.load : '0;
                    if (!q.ctrl.arl) d.ctrl.run = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
                mat = q.ctrl.cmp_en && (d.cnt == q.match);
            end
        end else begin
            d.pre = '0;
        end

        case (q.ctrl.evsel)
            2'b01:   evt = ovf;
            2'b10:   evt = ovf | mat;
            default: evt = 1'b0;
        endcase
        d.pwm = q.ctrl.tgl ? (q.pwm ^ evt) : (q.ctrl.idle ^ evt);

        // landed register transfers override local updates
        if (land_i[CH_CTRL]) begin
            d.ctrl = ctrl_i;
            d.pre  = '0;
            d.pwm  = ctrl_i.idle;
        end
        if (land_i[CH_LOAD])  d.load  = load_i;
        if (land_i[CH_MATCH]) d.match = match_i;
        if (land_i[CH_TRIG])  d.cnt   = d.load;
        if (land_i[CH_COUNT]) d.cnt   = cnt_i;

        // return paths: continuous counter snapshot and sticky events
        snap_start_o = !snap_busy_i;
        if (snap_start_o) d.snap = q.cnt;
        ev_go = q.evp & ~ev_busy_i;
        d.evp = (q.evp & ~ev_go) | {mat, ovf};
    end

    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ev_start_o = ev_go;
    assign snap_o     = q.snap;
    assign pwm_o      = q.pwm;
endmodule

// File: rtl/posted_timer.sv
module posted_timer
    import ptmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PRE_W  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic              bclk,
    input  logic              fclk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq,
    output logic              pwm_out
);
    localparam int unsigned NRET = 3;   // 0 overflow, 1 match, 2 snapshot

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
        logic [CNT_W-1:0] cnt_rd;
        logic [1:0]       stat;
        logic [1:0]       ien;
        logic             posted;
        logic             np_wait;
    } bus_t;

    bus_t q, d;
    logic [NCH-1:0]   go, pend, land;
    logic [NRET-1:0]  ret_go, ret_busy, ret_land;
    logic [CNT_W-1:0] snap;
    logic             treg;
    logic [2:0]       ch;

    // bus-domain to timer-domain register channels
    for (genvar i = 0; i < NCH; i++) begin : g_wr
        ptmr_xfer #(.STAGES(STAGES)) u_x (
            .src_clk(bclk), .dst_clk(fclk), .rst_n(rst_n),
            .start(go[i]), .busy(pend[i]), .land(land[i]));
    end

    // timer-domain to bus-domain event and snapshot channels
    for (genvar i = 0; i < NRET; i++) begin : g_rt
        ptmr_xfer #(.STAGES(STAGES)) u_x (
            .src_clk(fclk), .dst_clk(bclk), .rst_n(rst_n),
            .start(ret_go[i]), .busy(ret_busy[i]), .land(ret_land[i]));
    end

    ptmr_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
        .fclk(fclk), .rst_n(rst_n), .land_i(land),
        .ctrl_i(q.ctrl), .cnt_i(q.cnt), .load_i(q.load), .match_i(q.match),
        .snap_busy_i(ret_busy[2]), .ev_busy_i(ret_busy[1:0]),
        .snap_start_o(ret_go[2]), .snap_o(snap), .ev_start_o(ret_go[1:0]),
        .pwm_o(pwm_out));

    always_comb begin
        d         = q;
        go        = '0;
        bus_ready = 1'b1;
        treg      = (bus_addr < ADDR_W'(NCH));
        ch        = bus_addr[2:0];

        if (bus_we) begin
            if (treg) begin
                if (q.np_wait) begin
                    bus_ready = !pend[ch];
                    if (bus_ready) d.np_wait = 1'b0;
                end else if (!pend[ch]) begin
                    go[ch]    = 1'b1;
                    bus_ready = q.posted;
                    if (!q.posted) d.np_wait = 1'b1;
                    case (bus_addr)
                        AD_CTRL:  d.ctrl  = ctrl_unpack(bus_wdata);
                        AD_COUNT: d.cnt   = bus_wdata[CNT_W-1:0];
                        AD_LOAD:  d.load  = bus_wdata[CNT_W-1:0];
                        AD_MATCH: d.match = bus_wdata[CNT_W-1:0];
                        default:  ;
                    endcase
                end else begin
                    // posted: dropped; non-posted: hold until channel frees
                    bus_ready = q.posted;
                end
            end else begin
                case (bus_addr)
                    AD_STAT: d.stat   = q.stat & ~bus_wdata[1:0];
                    AD_IEN:  d.ien    = bus_wdata[1:0];
                    AD_IFC:  d.posted = bus_wdata[0];
                    default: ;
                endcase
            end
        end

        d.stat = d.stat | ret_land[1:0];
        if (ret_land[2]) d.cnt_rd = snap;

        case (bus_addr)
            AD_CTRL:  bus_rdata = ctrl_pack(q.ctrl);
            AD_COUNT: bus_rdata = DATA_W'(q.cnt_rd);
            AD_LOAD:  bus_rdata = DATA_W'(q.load);
            AD_MATCH: bus_rdata = DATA_W'(q.match);
            AD_PEND:  bus_rdata = DATA_W'(pend);
            AD_STAT:  bus_rdata = DATA_W'(q.stat);
            AD_IEN:   bus_rdata = DATA_W'(q.ien);
            AD_IFC:   bus_rdata = DATA_W'(q.posted);
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq = |(q.stat & q.ien);

    // plain views for the bound checker
    logic [CNT_W-1:0] load_view;
    logic [1:0]       stat_view, ev_land_view;
    logic             posted_view, np_wait_view;
    assign load_view    = q.load;
    assign stat_view    = q.stat;
    assign ev_land_view = ret_land[1:0];
    assign posted_view  = q.posted;
    assign np_wait_view = q.np_wait;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              bclk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic [NCH-1:0]    pend,
    input logic              posted,
    input logic              np_wait,
    input logic [1:0]        stat,
    input logic [1:0]        ev_land,
    input logic [CNT_W-1:0]  load_q
);
    AST_POSTED_READY: assert property (@(posedge bclk) disable iff (!rst_n)
        (posted && !np_wait) |-> bus_ready); // R2

    AST_PEND_RISES: assert property (@(posedge bclk) disable iff (!rst_n)
        (bus_we && bus_addr == AD_LOAD && !np_wait && !pend[CH_LOAD]) |=> pend[CH_LOAD]); // R2

    AST_NONPOSTED_STALL: assert property (@(posedge bclk) disable iff (!rst_n)
        (!posted && !np_wait && bus_we && bus_addr < ADDR_W'(NCH)) |-> !bus_ready); // R3

    AST_DROP_KEEPS: assert property (@(posedge bclk) disable iff (!rst_n)
        (posted && bus_we && bus_addr == AD_LOAD && pend[CH_LOAD]) |=> $stable(load_q)); // R4

    AST_STAT_CLEAR: assert property (@(posedge bclk) disable iff (!rst_n)
        (bus_we && bus_ready && bus_addr == AD_STAT && bus_wdata[0] && !ev_land[0]) |=> !stat[0]); // R13
endmodule

bind posted_timer ptmr_chk #(.CNT_W(CNT_W)) u_chk (
    .bclk(bclk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .pend(pend),
    .posted(posted_view), .np_wait(np_wait_view), .stat(stat_view),
    .ev_land(ev_land_view), .load_q(load_view));

// File: tb/posted_timer_test.sv
`timescale 1ns/1ps
module posted_timer_test;
    logic        bclk = 0, fclk = 0, rst_n = 0;
    logic        bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_ready, irq, pwm_out;
    int checks = 0, fails = 0, fcyc = 0;
    int ivs [0:3];

    always #10 bclk = ~bclk;   // 50 MHz
    always #17 fclk = ~fclk;
    always @(posedge fclk) fcyc++;

    posted_timer uut (.bclk(bclk), .fclk(fclk), .rst_n(rst_n), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .pwm_out(pwm_out));

    function automatic [31:0] mkctrl(bit run, bit arl, int ratio, bit pre, bit cmp,
                                      bit idle, int evsel, bit tgl);
        return {19'd0, tgl, 2'(evsel), 2'b00, idle, cmp, pre, 3'(ratio), arl, run};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input [3:0] a, input [31:0] v, output int stalls);
        @(negedge bclk); bus_we = 1; bus_addr = a; bus_wdata = v; stalls = 0; #1;
        while (!bus_ready) begin stalls++; @(negedge bclk); #1; end
        @(posedge bclk); #1; bus_we = 0;
    endtask

    task automatic wrq(input [3:0] a, input [31:0] v);
        int s;
        wr(a, v, s);
    endtask

    task automatic rd(input [3:0] a, output [31:0] v);
        @(negedge bclk); bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] p;
        int n = 0;
        do begin rd(4'd5, p); n++; end while (p != 0 && n < 200);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge bclk);
    endtask

    task automatic measure(int n);
        logic prv = pwm_out;
        int last = 0, k = 0;
        bit first = 1;
        while (k < n) begin
            @(negedge fclk);
            if (pwm_out !== prv) begin
                prv = pwm_out;
                if (!first) begin ivs[k] = fcyc - last; k++; end
                first = 0;
                last = fcyc;
            end
        end
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, x, y, ld;
        int s, off, r, div;
        void'($urandom(32'd4242));
        repeat (3) @(negedge bclk);
        rst_n = 1;
        settle(2);

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        rd(4'd1, v); chk("R1 count", v, 0);
        rd(4'd5, v); chk("R1 pend", v, 0);
        rd(4'd6, v); chk("R1 stat", v, 0);
        rd(4'd8, v); chk("R1 ifctl", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pwm", pwm_out, 0);

        // R2 posted write, R4 drop
        wrq(4'd8, 1);
        wr(4'd2, 32'hA5A5_0001, s); chk("R2 no stall", s, 0);
        rd(4'd5, v); chk("R2 load pending", v, 32'h4);
        wrq(4'd2, 32'h1234_5678);
        wait_idle();
        rd(4'd5, v); chk("R2 pending cleared", v, 0);
        rd(4'd2, v); chk("R4 dropped write", v, 32'hA5A5_0001);
        // R6 trigger reload
        wrq(4'd3, 0); wait_idle(); settle(30);
        rd(4'd1, v); chk("R6 trigger reload", v, 32'hA5A5_0001);

        // R5 / R6 random presets
        for (int i = 0; i < 6; i++) begin
            x = $urandom;
            wrq(4'd1, x); wait_idle(); settle(30);
            rd(4'd1, v); chk("R5 counter preset", v, x);
            y = $urandom;
            wrq(4'd2, y); wait_idle(); wrq(4'd3, 0); wait_idle(); settle(30);
            rd(4'd1, v); chk("R6 random reload", v, y);
        end

        // R3 non-posted
        wrq(4'd8, 0);
        wr(4'd1, 32'h55, s); chk("R3 stalled", 32'(s > 0), 1);
        rd(4'd5, v); chk("R3 done at release", v, 0);
        settle(30);
        rd(4'd1, v); chk("R3 value landed", v, 32'h55);
        wrq(4'd8, 1);

        // R10 stop freezes counter
        wrq(4'd1, 0); wait_idle();
        wrq(4'd0, mkctrl(1,0,0,0,0,0,0,0)); wait_idle(); settle(40);
        wrq(4'd0, 0); wait_idle(); settle(30);
        rd(4'd1, x); settle(40); rd(4'd1, y);
        chk("R10 counted", 32'(x != 0), 1);
        chk("R10 frozen", y, x);

        // R7 / R8 / R12 period by toggle edges
        for (int i = 0; i < 5; i++) begin
            off = 4 + int'($urandom % 16);
            r   = int'($urandom % 3);
            div = (i == 0) ? 1 : (1 << (r + 1));
            ld  = 32'(0) - 32'(off);
            wrq(4'd0, 0); wait_idle();
            wrq(4'd2, ld); wait_idle(); wrq(4'd3, 0); wait_idle();
            wrq(4'd0, mkctrl(1,1,r,(i != 0),0,0,1,1)); wait_idle();
            measure(3);
            chk("R8 R7 period a", ivs[1], 32'(off * div));
            chk("R12 R7 period b", ivs[2], 32'(off * div));
        end

        // R11 match with overflow-or-match toggle
        wrq(4'd0, 0); wait_idle();
        wrq(4'd6, 3);
        wrq(4'd2, 32'hFFFF_FFF0); wait_idle(); wrq(4'd3, 0);
        wrq(4'd4, 32'hFFFF_FFFC); wait_idle();
        wrq(4'd0, mkctrl(1,1,0,0,1,0,2,1)); wait_idle();
        measure(3);
        chk("R11 sum", ivs[0] + ivs[1], 16);
        chk("R11 split", 32'(ivs[0] == 4 || ivs[0] == 12), 1);
        chk("R11 repeat", ivs[2], ivs[0]);

        // R13 status and irq
        wrq(4'd7, 1);
        wrq(4'd0, 0); wait_idle(); settle(30);
        rd(4'd6, v); chk("R13 R11 status", v, 3);
        chk("R13 irq on", irq, 1);
        wrq(4'd6, 1); rd(4'd6, v); chk("R13 clear ovf", v, 2);
        chk("R13 irq masked", irq, 0);
        wrq(4'd6, 0); rd(4'd6, v); chk("R13 write 0 no effect", v, 2);
        wrq(4'd7, 2); settle(1); chk("R13 irq match", irq, 1);
        wrq(4'd6, 2); settle(1); chk("R13 irq cleared", irq, 0);

        // R9 halt without auto-reload
        wrq(4'd1, 32'hFFFF_FFFB); wait_idle();
        wrq(4'd0, mkctrl(1,0,0,0,0,0,0,0)); wait_idle(); settle(60);
        rd(4'd1, v); chk("R9 wrapped to zero", v, 0);
        settle(40); rd(4'd1, v); chk("R9 stays halted", v, 0);

        // R12 idle level and pulse mode
        wrq(4'd0, mkctrl(0,0,0,0,0,1,0,0)); wait_idle(); @(negedge fclk);
        chk("R12 idle level", pwm_out, 1);
        wrq(4'd2, 32'hFFFF_FFF6); wait_idle(); wrq(4'd3, 0); wait_idle();
        wrq(4'd0, mkctrl(1,1,0,0,0,1,1,0)); wait_idle();
        measure(4);
        chk("R12 pulse width", 32'((ivs[0] == 1 && ivs[1] == 9) || (ivs[0] == 9 && ivs[1] == 1)), 1);
        chk("R12 pulse period", ivs[2] + ivs[3], 10);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule